// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block is a single-master I2C byte engine that sits behind a small file of eight-bit registers. Software sets the bus role, the direction and the acknowledge policy through a control byte. Setting the master bit puts a START condition on the bus, and clearing it puts a STOP condition on the bus. Each write to the data byte moves one byte plus its acknowledge slot. When the block transmits, the write supplies the byte to send. When it receives, the write is a dummy that only clocks a byte in.

A status byte reports:
- transfer completion;
- bus activity seen on the wires;
- lost arbitration;
- a pending interrupt;
- the acknowledge level read in the ninth slot.

The bus pins are open-drain. Each line has a drive-low enable and a sampled input. An interrupt output combines the pending flag with an enable bit. A repeated START can be requested between bytes. If another master wins arbitration, the block drops master mode and releases both lines without a STOP.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control byte (offset 2) reads 0x80 and the status byte (offset 3) reads 0x80. Both line enables and the interrupt output are low.
- R2: While control bit 7 (disable) is set, no bus activity occurs and both lines stay released. The registers can still be written and read back unchanged, for example 0xA0 written to control reads 0xA0.
- R3: The offsets are: 0 own address, 1 divider, 2 control, 3 status, 4 data, 5 interrupt config, 6 debug. Offsets 0, 5 and 6 are plain read/write storage.
- R4: With disable clear, setting control bit 5 (master) produces a START on the bus, meaning SDA falls while SCL is high. The bus-busy flag (status bit 5) then sets.
- R5: The SCL high time of a bit equals max(divider,1)+1 clock cycles.
- R6: With control bit 4 (transmit) set, a data write sends the byte MSB first. Status bit 0 then holds the SDA level of the ninth slot: 0 means acknowledged, 1 means not.
- R7: With control bit 4 clear, a data write clocks a byte in, MSB first, and the data byte then reads as that byte. In the ninth slot the block drives SDA low unless control bit 3 (acknowledge disable) is set, in which case it leaves SDA high.
- R8: Control bit 3 has no effect while transmitting: the block always releases SDA in the ninth slot.
- R9: Status bit 7 (done) is 0 while a byte is in progress. At the end of the ninth slot, status bits 7 and 1 (pending) set together. The interrupt output equals bit 1 AND control bit 6. Writing a 1 to status bit 1 clears it.
- R10: Writing control with bit 2 set, while the block is master and between bytes, produces a repeated START with no STOP before it. Bit 2 always reads back as 0.
- R11: Clearing control bit 5 while master produces a STOP once the current byte ends. Bus-busy then clears.
- R12: If the block releases SDA for a 1 but samples SDA low while SCL is high in a data slot, it does three things. It clears control bit 5, releases both lines without a STOP, and sets status bit 4. Status bit 4 stays set until a 1 is written to it.
- R13: Bus-busy follows the wires: it sets on any START and clears on any STOP, including conditions made by another device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| scl_in | input | 1 | Sampled SCL level |
| scl_oe | output | 1 | Drive SCL low when 1 |
| sda_in | input | 1 | Sampled SDA level |
| sda_oe | output | 1 | Drive SDA low when 1 |
| irq | output | 1 | Interrupt request |

## Verification
Each fault shows up at the ports within about one bit time:
- A wrong phase or bit counter shifts the byte seen on SDA by one position, or moves the ninth-slot acknowledge. It can also make status bit 1 set early or late.
- A timer fault changes the measured SCL high width on the very next bit.
- A faulty arbitration path shows up as control bit 5 still set, a STOP seen on the wires, or a line still held after the losing slot.
- A faulty bus-busy tracker disagrees with the START and STOP events that the bench counts on the wires.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  output logic       scl_oe,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic       irq
);
  localparam logic [2:0] A_OWN = 3'd0, A_DIV = 3'd1, A_CTL = 3'd2, A_STA = 3'd3,
                         A_DAT = 3'd4, A_ICF = 3'd5, A_DBG = 3'd6;
  typedef enum logic [2:0] {S_IDLE, S_START, S_HOLD, S_BITS, S_STOP, S_RST} st_t;

  st_t        st;
  logic [7:0] own_q, div_q, ctl_q, icf_q, dbg_q, shf_q, cnt_q;
  logic [1:0] ph_q;
  logic [3:0] bit_q;
  logic       tcf_q, bb_q, al_q, if_q, rxak_q, scl_d, sda_d;

  logic off, ie, mst, tx, nak, wr_ctl, wr_dat, wr_sta, run, adv, smp, arb, drv;
  logic [7:0] lim;

  assign off    = ctl_q[7];
  assign ie     = ctl_q[6];
  assign mst    = ctl_q[5];
  assign tx     = ctl_q[4];
  assign nak    = ctl_q[3];
  assign wr_ctl = reg_we && reg_addr == A_CTL;
  assign wr_dat = reg_we && reg_addr == A_DAT;
  assign wr_sta = reg_we && reg_addr == A_STA;
  assign run    = st == S_START || st == S_BITS || st == S_STOP || st == S_RST;
  assign lim    = (div_q == 8'd0) ? 8'd1 : div_q;
  assign adv    = run && cnt_q == lim;
  assign smp    = st == S_BITS && adv && ph_q == 2'd1;
  assign arb    = smp && bit_q < 4'd8 && tx && shf_q[7] && !sda_in;
  assign drv    = (bit_q == 4'd8) ? (!tx && !nak) : (tx && !shf_q[7]);
  assign irq    = if_q & ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0; div_q <= '0; ctl_q <= 8'h80; icf_q <= '0; dbg_q <= '0;
    end else begin
      if (reg_we)
        case (reg_addr)
          A_OWN:   own_q <= reg_wdata;
          A_DIV:   div_q <= reg_wdata;
          A_CTL:   ctl_q <= reg_wdata & 8'hFB;
          A_ICF:   icf_q <= reg_wdata;
          A_DBG:   dbg_q <= reg_wdata;
          default: ;
        endcase
      if (arb) ctl_q[5] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt_q <= '0; ph_q <= '0; bit_q <= '0; shf_q <= '0;
      tcf_q <= 1'b1; bb_q <= 1'b0; al_q <= 1'b0; if_q <= 1'b0; rxak_q <= 1'b0;
      scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_d <= scl_in;
      sda_d <= sda_in;
      cnt_q <= (!run || adv) ? 8'd0 : cnt_q + 8'd1;
      if (wr_sta && reg_wdata[4]) al_q <= 1'b0;
      if (wr_sta && reg_wdata[1]) if_q <= 1'b0;
      if (scl_d && scl_in && sda_d && !sda_in) bb_q <= 1'b1;
      else if (scl_d && scl_in && !sda_d && sda_in) bb_q <= 1'b0;
      if (wr_dat && (st == S_HOLD || st == S_IDLE)) shf_q <= reg_wdata;
      case (st)
        S_IDLE: if (mst) begin st <= S_START; ph_q <= 2'd0; end
        S_START: if (adv) begin
          if (ph_q == 2'd1) begin st <= S_HOLD; ph_q <= 2'd0; end
          else ph_q <= ph_q + 2'd1;
        end
        S_HOLD:
          if (!mst) begin st <= S_STOP; ph_q <= 2'd0; end
          else if (wr_ctl && reg_wdata[5] && reg_wdata[2]) begin st <= S_RST; ph_q <= 2'd0; end
          else if (wr_dat) begin st <= S_BITS; ph_q <= 2'd0; bit_q <= 4'd0; tcf_q <= 1'b0; end
        S_BITS: if (adv) begin
          if (ph_q == 2'd0) ph_q <= 2'd1;
          else if (arb) begin
            st <= S_IDLE; ph_q <= 2'd0; al_q <= 1'b1;
          end else begin
            ph_q <= 2'd0;
            if (bit_q == 4'd8) begin
              st <= S_HOLD; tcf_q <= 1'b1; if_q <= 1'b1; rxak_q <= sda_in;
            end else begin
              shf_q <= {shf_q[6:0], sda_in};
              bit_q <= bit_q + 4'd1;
            end
          end
        end
        S_STOP, S_RST: if (adv) begin
          if (ph_q == 2'd2) begin st <= (st == S_STOP) ? S_IDLE : S_HOLD; ph_q <= 2'd0; end
          else ph_q <= ph_q + 2'd1;
        end
        default: st <= S_IDLE;
      endcase
      if (off) begin
        st <= S_IDLE; cnt_q <= '0; ph_q <= '0;
        tcf_q <= 1'b1; bb_q <= 1'b0; al_q <= 1'b0; if_q <= 1'b0; rxak_q <= 1'b0;
      end
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: sda_oe = ph_q == 2'd1;
      S_HOLD:  begin scl_oe = 1'b1; sda_oe = 1'b1; end
      S_BITS:  begin scl_oe = ph_q == 2'd0; sda_oe = drv; end
      S_STOP:  begin scl_oe = ph_q == 2'd0; sda_oe = ph_q != 2'd2; end
      S_RST:   begin scl_oe = ph_q == 2'd0; sda_oe = ph_q == 2'd2; end
      default: ;
    endcase
  end

  always_comb
    case (reg_addr)
      A_OWN:   reg_rdata = own_q;
      A_DIV:   reg_rdata = div_q;
      A_CTL:   reg_rdata = ctl_q;
      A_STA:   reg_rdata = {tcf_q, 1'b0, bb_q, al_q, 2'b00, if_q, rxak_q};
      A_DAT:   reg_rdata = shf_q;
      A_ICF:   reg_rdata = icf_q;
      A_DBG:   reg_rdata = dbg_q;
      default: reg_rdata = 8'h00;
    endcase
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl,
  input logic [2:0] st,
  input logic [7:0] cnt,
  input logic       al,
  input logic       iflag,
  input logic       tcf,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_rdata
);
  localparam logic [2:0] C_IDLE = 3'd0, C_BITS = 3'd3;

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[7] && $past(ctl[7])) |-> (!scl_oe && !sda_oe));

  // R10
  rsta_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd2) |-> !reg_rdata[2]);

  // R12
  arb_no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(al) |-> (st == C_IDLE && !ctl[5]));

  // R9
  flag_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflag) |-> tcf);

  // R5
  scl_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 8'd0) |-> $stable(scl_oe));

  // R6
  sda_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_BITS && $past(st == C_BITS) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));
endmodule

bind i2c_byte_master i2c_byte_master_chk chk (
  .clk(clk), .rst_n(rst_n), .ctl(ctl_q), .st(st), .cnt(cnt_q), .al(al_q),
  .iflag(if_q), .tcf(tcf_q), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata));

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic slv_low = 1'b0;
  logic scl_in, sda_in;
  assign scl_in = ~scl_oe;
  assign sda_in = ~sda_oe & ~slv_low;

  int errs = 0, checks = 0, cyc = 0;
  int bidx = 9, starts = 0, stops = 0, hi_run = 0, hi_last = 0, arb_bit = 99;
  logic [7:0] cap = '0, rx_byte = '0;
  logic ackbit = 1'b0, slv_ack = 1'b0, rx_mode = 1'b0, kill = 1'b0;
  logic pscl = 1'b1, psda = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  i2c_byte_master uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_in),
    .scl_oe(scl_oe), .sda_in(sda_in), .sda_oe(sda_oe), .irq(irq));

  always @(negedge clk) begin
    logic s, d;
    s = scl_in;
    d = sda_in;
    if (pscl && s && psda && !d) begin starts++; bidx = 9; end
    if (pscl && s && !psda && d) stops++;
    if (!pscl && s) begin
      hi_run = 1;
      if (bidx < 8) cap = {cap[6:0], d};
      else if (bidx == 8) ackbit = d;
    end else if (s) hi_run++;
    if (pscl && !s) begin
      hi_last = hi_run;
      bidx = (bidx >= 8) ? 0 : bidx + 1;
    end
    slv_low = (bidx == arb_bit) || (rx_mode && bidx < 8 && !rx_byte[7 - bidx])
              || (!rx_mode && bidx == 8 && slv_ack);
    if (kill) slv_low = 1'b0;
    pscl = s;
    psda = d;
  end

  function automatic logic [7:0] exp_status(input logic tcf, bb, al, ifl, rxak);
    return {tcf, 1'b0, bb, al, 2'b00, ifl, rxak};
  endfunction

  function automatic int half_cycles(input logic [7:0] dv);
    return ((dv == 8'd0) ? 1 : int'(dv)) + 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_flag(input string req);
    logic [7:0] v;
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      rd(3'd3, v);
      seen = v[1];
    end
    chk(req, seen, 1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, dv, b;
    int s0, p0, hw;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd2, v); chk("R1 ctrl", v, 8'h80);
    rd(3'd3, v); chk("R1 status", v, 8'h80);
    chk("R1 lines", {scl_oe, sda_oe, irq}, 3'b000);

    wr(3'd0, 8'h5A); wr(3'd5, 8'hC3); wr(3'd6, 8'h3C);
    rd(3'd0, v); chk("R3 own", v, 8'h5A);
    rd(3'd5, v); chk("R3 icfg", v, 8'hC3);
    rd(3'd6, v); chk("R3 dbg", v, 8'h3C);

    wr(3'd2, 8'hA0);
    repeat (40) @(negedge clk);
    chk("R2 no start", starts, 0);
    chk("R2 released", {scl_oe, sda_oe}, 2'b00);
    rd(3'd2, v); chk("R2 ctrl readback", v, 8'hA0);

    dv = 8'($urandom_range(0, 6));
    hw = half_cycles(dv);
    wr(3'd1, dv);
    rd(3'd1, v); chk("R3 div", v, dv);

    wr(3'd2, 8'h70);
    repeat (6 * hw + 4) @(negedge clk);
    chk("R4 start seen", starts, 1);
    rd(3'd3, v); chk("R4 busy", v, exp_status(1, 1, 0, 0, 0));

    for (int k = 0; k < 6; k++) begin
      b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
      slv_ack = (k == 0) ? 1'b0 : (k == 1) ? 1'b1 : 1'($urandom);
      wr(3'd4, b);
      rd(3'd3, v); chk("R9 done low", v[7], 1'b0);
      wait_flag("R9 flag");
      chk("R6 byte", cap, b);
      rd(3'd3, v); chk("R6 status", v, exp_status(1, 1, 0, 1, !slv_ack));
      chk("R9 irq", irq, 1'b1);
      chk("R5 high width", hi_last, hw);
      wr(3'd3, 8'h02);
      chk("R9 irq cleared", irq, 1'b0);
      rd(3'd3, v); chk("R9 w1c", v, exp_status(1, 1, 0, 0, !slv_ack));
    end

    wr(3'd2, 8'h78);
    slv_ack = 1'b0;
    wr(3'd4, 8'($urandom));
    wait_flag("R8 flag");
    chk("R8 ack released", ackbit, 1'b1);
    rd(3'd3, v); chk("R8 rxak", v[0], 1'b1);
    wr(3'd3, 8'h02);

    rx_mode = 1'b1;
    for (int k = 0; k < 2; k++) begin
      rx_byte = 8'($urandom);
      wr(3'd2, (k == 0) ? 8'h60 : 8'h68);
      wr(3'd4, 8'h00);
      wait_flag("R7 flag");
      rd(3'd4, v); chk("R7 rx byte", v, rx_byte);
      chk("R7 ack level", ackbit, (k == 0) ? 1'b0 : 1'b1);
      wr(3'd3, 8'h02);
    end
    rx_mode = 1'b0;
    repeat (2) @(negedge clk);

    s0 = starts; p0 = stops;
    wr(3'd2, 8'h74);
    repeat (8 * hw + 4) @(negedge clk);
    chk("R10 restart", starts, s0 + 1);
    chk("R10 no stop", stops, p0);
    rd(3'd2, v); chk("R10 reads zero", v, 8'h70);
    slv_ack = 1'b1;
    wr(3'd4, 8'hA5);
    wait_flag("R10 flag");
    chk("R10 byte after restart", cap, 8'hA5);
    wr(3'd3, 8'h02);

    p0 = stops;
    wr(3'd2, 8'h50);
    repeat (8 * hw + 4) @(negedge clk);
    chk("R11 stop", stops, p0 + 1);
    rd(3'd3, v); chk("R11 not busy", v[5], 1'b0);
    chk("R11 released", {scl_oe, sda_oe}, 2'b00);

    wr(3'd2, 8'h70);
    repeat (6 * hw + 4) @(negedge clk);
    arb_bit = 2;
    slv_ack = 1'b0;
    p0 = stops;
    wr(3'd4, 8'hFF);
    repeat (12 * hw + 20) @(negedge clk);
    rd(3'd3, v); chk("R12 lost flag", v, exp_status(0, 1, 1, 0, 0));
    rd(3'd2, v); chk("R12 master dropped", v, 8'h50);
    chk("R12 released", {scl_oe, sda_oe}, 2'b00);
    chk("R12 no stop", stops, p0);
    wr(3'd3, 8'h00);
    rd(3'd3, v); chk("R12 sticky", v[4], 1'b1);
    wr(3'd3, 8'h10);
    rd(3'd3, v); chk("R12 w1c", v[4], 1'b0);

    chk("R13 busy held", v[5], 1'b1);
    kill = 1'b1;
    arb_bit = 99;
    repeat (4) @(negedge clk);
    chk("R13 external stop", stops, p0 + 1);
    rd(3'd3, v); chk("R13 busy cleared", v[5], 1'b0);
    kill = 1'b0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule